// File: doc/BRIEF.md
# Dual-Accumulator Integer Operate Unit

This unit runs the integer operate instructions of a small accumulator machine. Each instruction names two 64-bit accumulators, A and B, by an 8-bit opcode. The unit normally writes the result of A op B back into A. There are three exceptions. Swap exchanges the two accumulators. Extended multiply writes its double-width product across both accumulators. Extended divide returns the remainder and the quotient together. The caller presents the opcode and both accumulator values with a one-cycle start strobe. When done pulses, the caller reads back the new accumulator values and five condition flags.

A type register sets the operand width. An opcode of the form 11101nnn loads it, and only type codes 0 to 3 are accepted. Arithmetic is carried out at that width. Results are zero-extended to 64 bits, and the flags are computed at that width. Add, subtract and the logical operations take one cycle. Multiply and divide run one iteration per operand bit.

Top module: `accop_unit`

## Requirements
- R1: While reset is high and in the cycle after it falls, both accumulator outputs and all flags read zero, done is low, and the type register holds 3 (64-bit).
- R2: Opcode 11101nnn with nnn of 0, 1, 2 or 3 selects 8, 16, 32 or 64-bit operands. With nnn of 4 to 7 the type is kept. In every case done pulses and the accumulator and flag outputs hold.
- R3: Add (10100100) and subtract (10100101) write (A plus or minus B) modulo 2^w into A, zero-extended, and pass B through. Carry is the carry out of add or the borrow of subtract. Overflow is two's-complement overflow at width w.
- R4: XOR (10101011), AND (10101100) and OR (10101101) write the bitwise result into A and pass B through. Carry and overflow are cleared.
- R5: Swap (10100000) returns the full 64-bit B in A and the full 64-bit A in B. Carry and overflow are cleared.
- R6: Multiply (10100110) writes the low w bits of the unsigned product into A and passes B through. Extended multiply (10101110) writes the high w bits into A and the low w bits into B.
- R7: Divide (10100111) writes the unsigned quotient into A and passes B through. Extended divide (10101111) writes the remainder into A and the quotient into B.
- R8: A divide of either kind whose divisor is zero at width w returns A and B exactly as presented. It sets overflow and clears carry.
- R9: Every result-writing operation sets low, equal and high from the value written into A, read as a signed w-bit number: low if bit w-1 is set, equal if it is zero, high otherwise. Multiply and divide clear carry and overflow.
- R10: The other operate-range opcodes (10100001 to 10100011, 10101000 to 10101010), and any opcode outside the operate and type ranges, only pulse done. All other outputs keep their previous values.
- R11: Single-cycle operations pulse done one cycle after start. Multiply and divide pulse done within w+3 cycles. A start while a multiply or divide is running is ignored.
- R12: Accumulator bits above width w do not affect any arithmetic or logical result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that issues `opcode` |
| opcode | input | 8 | Instruction byte |
| a_in | input | 64 | Current value of accumulator A |
| b_in | input | 64 | Current value of accumulator B |
| a_out | output | 64 | New value of accumulator A |
| b_out | output | 64 | New value of accumulator B |
| flag_carry | output | 1 | Carry out or borrow |
| flag_ovf | output | 1 | Signed overflow, or divide by zero |
| flag_low | output | 1 | Result negative |
| flag_eq | output | 1 | Result zero |
| flag_high | output | 1 | Result positive |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets width-dependent carry and overflow: a byte add that wraps to zero, and a byte add that crosses into the sign bit. A unit that took carry from bit 63, or sign from the full word, would report wrong flags on both. It feeds operands with set bits above the active width to catch missing masking. It also runs an extended multiply at full width, where a product register narrower than 128 bits would lose the high half. It checks a divide whose divisor is non-zero in 64 bits but zero in 32, which a unit testing the unmasked divisor would try to divide. Finally it issues a second start during a running multiply, an invalid type code and an unused opcode, each of which a careless decoder would let disturb the accumulators or the width.

// File: rtl/accop_pkg.sv
package accop_pkg;

  typedef enum logic [3:0] {
    K_NONE, K_SWAP, K_ADD, K_SUB, K_MUL, K_DIV,
    K_XOR, K_AND, K_OR, K_MULX, K_DIVX, K_SETT
  } op_kind_e;

  typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_DIV} unit_state_e;

  function automatic op_kind_e decode_op(input logic [7:0] op);
    op_kind_e k;
    k = K_NONE;
    if (op[7:3] == 5'b11101) k = K_SETT;
    else case (op)
      8'b1010_0000: k = K_SWAP;
      8'b1010_0100: k = K_ADD;
      8'b1010_0101: k = K_SUB;
      8'b1010_0110: k = K_MUL;
      8'b1010_0111: k = K_DIV;
      8'b1010_1011: k = K_XOR;
      8'b1010_1100: k = K_AND;
      8'b1010_1101: k = K_OR;
      8'b1010_1110: k = K_MULX;
      8'b1010_1111: k = K_DIVX;
      default:      k = K_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/accop_logic.sv
module accop_logic
  import accop_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int CNT_W = $clog2(DATA_W + 1),
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  op_kind_e            kind,
  input  logic [DATA_W-1:0]   a_raw,
  input  logic [DATA_W-1:0]   b_raw,
  input  logic [DATA_W-1:0]   mask,
  input  logic [CNT_W-1:0]    wid,
  output logic [DATA_W-1:0]   res_a,
  output logic [DATA_W-1:0]   res_b,
  output logic                res_c,
  output logic                res_v
);
  logic [DATA_W-1:0] am, bm;
  logic [DATA_W:0]   sum;
  logic [IDX_W-1:0]  msb;
  logic              sa, sb, sr;

  assign am  = a_raw & mask;
  assign bm  = b_raw & mask;
  assign sum = {1'b0, am} + {1'b0, bm};
  assign msb = IDX_W'(wid - 1'b1);
  assign sa  = am[msb];
  assign sb  = bm[msb];
  assign sr  = res_a[msb];

  always_comb begin
    res_a = a_raw;
    res_b = b_raw;
    res_c = 1'b0;
    res_v = 1'b0;
    case (kind)
      K_SWAP: begin
        res_a = b_raw;
        res_b = a_raw;
      end
      K_ADD: begin
        res_a = sum[DATA_W-1:0] & mask;
        res_c = sum[wid];
        res_v = (sa == sb) && (sr != sa);
      end
      K_SUB: begin
        res_a = (am - bm) & mask;
        res_c = (am < bm);
        res_v = (sa != sb) && (sr != sa);
      end
      K_XOR:   res_a = am ^ bm;
      K_AND:   res_a = am & bm;
      K_OR:    res_a = am | bm;
      default: ;
    endcase
  end
endmodule

// File: rtl/accop_mul.sv
module accop_mul #(
  parameter int DATA_W = 64,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go,
  input  logic [CNT_W-1:0]      steps,
  input  logic [DATA_W-1:0]     mcand_in,
  input  logic [DATA_W-1:0]     mplier_in,
  output logic                  fin,
  output logic [2*DATA_W-1:0]   prod
);
  logic [2*DATA_W-1:0] mc;
  logic [DATA_W-1:0]   mp;
  logic [CNT_W-1:0]    cnt;
  logic                run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      fin  <= 1'b0;
      cnt  <= '0;
      prod <= '0;
      mc   <= '0;
      mp   <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        run  <= 1'b1;
        cnt  <= steps;
        prod <= '0;
        mc   <= {{DATA_W{1'b0}}, mcand_in};
        mp   <= mplier_in;
      end else if (run) begin
        if (mp[0]) prod <= prod + mc;
        mc  <= mc << 1;
        mp  <= mp >> 1;
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  AST_MUL_SINGLE_FIN: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin); // R11
  AST_MUL_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    go |-> !run); // R11
endmodule

// File: rtl/accop_div.sv
module accop_div #(
  parameter int DATA_W = 64,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic [CNT_W-1:0]    steps,
  input  logic [DATA_W-1:0]   dividend,
  input  logic [DATA_W-1:0]   divisor,
  output logic                fin,
  output logic [DATA_W-1:0]   quo,
  output logic [DATA_W-1:0]   rem
);
  logic [DATA_W-1:0] dvs;
  logic [DATA_W:0]   trial;
  logic [CNT_W-1:0]  cnt;
  logic              run;

  assign trial = {rem, quo[DATA_W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      fin <= 1'b0;
      cnt <= '0;
      quo <= '0;
      rem <= '0;
      dvs <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        run <= 1'b1;
        cnt <= steps;
        rem <= '0;
        quo <= dividend << (CNT_W'(DATA_W) - steps);
        dvs <= divisor;
      end else if (run) begin
        if (trial >= {1'b0, dvs}) begin
          rem <= DATA_W'(trial - {1'b0, dvs});
          quo <= {quo[DATA_W-2:0], 1'b1};
        end else begin
          rem <= trial[DATA_W-1:0];
          quo <= {quo[DATA_W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  AST_DIV_REM_BELOW: assert property (@(posedge clk) disable iff (rst)
    (run || fin) |-> (rem < dvs)); // R7
  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (rst)
    go |-> (divisor != '0)); // R8
endmodule

// File: rtl/accop_unit.sv
module accop_unit
  import accop_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TYPE_W = 2,
  localparam int CNT_W = $clog2(DATA_W + 1),
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [63:0]       a_in,
  input  logic [63:0]       b_in,
  output logic [63:0]       a_out,
  output logic [63:0]       b_out,
  output logic              flag_carry,
  output logic              flag_ovf,
  output logic              flag_low,
  output logic              flag_eq,
  output logic              flag_high,
  output logic              done
);
  localparam logic [DATA_W-1:0] ONES = '1;

  unit_state_e       state;
  op_kind_e          kind, kind_q;
  logic [TYPE_W-1:0] typ_q;
  logic [CNT_W-1:0]  wid;
  logic [DATA_W-1:0] mask, am, bm, b_hold;
  logic [DATA_W-1:0] lg_a, lg_b, quo, rem, nxt_a, nxt_b;
  logic [2*DATA_W-1:0] prod;
  logic lg_c, lg_v, nxt_c, nxt_v, wr, fin_done, set_typ;
  logic mul_go, div_go, mul_fin, div_fin;

  function automatic logic [2:0] cmp_flags(input logic [DATA_W-1:0] v,
                                           input logic [DATA_W-1:0] m,
                                           input logic [CNT_W-1:0]  w);
    logic s, z;
    z = ((v & m) == '0);
    s = v[IDX_W'(w - 1'b1)];
    return {s, z, !s && !z};
  endfunction

  assign kind = decode_op(opcode);
  assign wid  = CNT_W'(8) << typ_q;
  assign mask = ONES >> (CNT_W'(DATA_W) - wid);
  assign am   = a_in & mask;
  assign bm   = b_in & mask;

  assign mul_go = (state == ST_IDLE) && start && (kind == K_MUL || kind == K_MULX);
  assign div_go = (state == ST_IDLE) && start && (kind == K_DIV || kind == K_DIVX)
                  && (bm != '0);

  accop_logic #(.DATA_W(DATA_W)) u_logic (
    .kind(kind), .a_raw(a_in), .b_raw(b_in), .mask(mask), .wid(wid),
    .res_a(lg_a), .res_b(lg_b), .res_c(lg_c), .res_v(lg_v));

  accop_mul #(.DATA_W(DATA_W)) u_mul (
    .clk(clk), .rst(rst), .go(mul_go), .steps(wid),
    .mcand_in(am), .mplier_in(bm), .fin(mul_fin), .prod(prod));

  accop_div #(.DATA_W(DATA_W)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .steps(wid),
    .dividend(am), .divisor(bm), .fin(div_fin), .quo(quo), .rem(rem));

  always_comb begin
    wr = 1'b0; fin_done = 1'b0; set_typ = 1'b0;
    nxt_a = a_out; nxt_b = b_out; nxt_c = 1'b0; nxt_v = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        fin_done = 1'b1;
        case (kind)
          K_SWAP, K_ADD, K_SUB, K_XOR, K_AND, K_OR: begin
            wr = 1'b1; nxt_a = lg_a; nxt_b = lg_b; nxt_c = lg_c; nxt_v = lg_v;
          end
          K_MUL, K_MULX: fin_done = 1'b0;
          K_DIV, K_DIVX:
            if (bm == '0) begin
              wr = 1'b1; nxt_a = a_in; nxt_b = b_in; nxt_v = 1'b1;
            end else fin_done = 1'b0;
          K_SETT:  set_typ = (opcode[2:0] < 3'd4);
          default: ;
        endcase
      end
      ST_MUL: if (mul_fin) begin
        wr = 1'b1; fin_done = 1'b1;
        if (kind_q == K_MULX) begin
          nxt_a = DATA_W'(prod >> wid) & mask;
          nxt_b = prod[DATA_W-1:0] & mask;
        end else begin
          nxt_a = prod[DATA_W-1:0] & mask;
          nxt_b = b_hold;
        end
      end
      ST_DIV: if (div_fin) begin
        wr = 1'b1; fin_done = 1'b1;
        if (kind_q == K_DIVX) begin
          nxt_a = rem;
          nxt_b = quo & mask;
        end else begin
          nxt_a = quo & mask;
          nxt_b = b_hold;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; kind_q <= K_NONE; typ_q <= TYPE_W'(3); b_hold <= '0;
      a_out <= '0; b_out <= '0; done <= 1'b0;
      flag_carry <= 1'b0; flag_ovf <= 1'b0;
      flag_low <= 1'b0; flag_eq <= 1'b0; flag_high <= 1'b0;
    end else begin
      done <= fin_done;
      if (set_typ) typ_q <= opcode[TYPE_W-1:0];
      if (mul_go || div_go) begin
        kind_q <= kind;
        b_hold <= b_in;
        state  <= mul_go ? ST_MUL : ST_DIV;
      end else if (fin_done) state <= ST_IDLE;
      if (wr) begin
        a_out <= nxt_a; b_out <= nxt_b;
        flag_carry <= nxt_c; flag_ovf <= nxt_v;
        {flag_low, flag_eq, flag_high} <= cmp_flags(nxt_a, mask, wid);
      end
    end
  end

  AST_SWAP_EXCHANGE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && kind == K_SWAP)
      |=> (done && a_out == $past(b_in) && b_out == $past(a_in))); // R5
  AST_DIV_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && (kind == K_DIV || kind == K_DIVX) && bm == '0)
      |=> (done && flag_ovf && !flag_carry
           && a_out == $past(a_in) && b_out == $past(b_in))); // R8
  AST_CMP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flag_low, flag_eq, flag_high})); // R9
  AST_BUSY_TYPE_HELD: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(typ_q)); // R11
endmodule

// File: tb/sim_accop_unit.sv
module sim_accop_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [63:0] a_in = '0, b_in = '0;
  logic [63:0] a_out, b_out;
  logic        flag_carry, flag_ovf, flag_low, flag_eq, flag_high, done;

  int checks = 0;
  int errors = 0;
  int cur_type = 3;
  int lat;

  always #2.5 clk = ~clk;

  accop_unit u0 (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .b_out(b_out), .flag_carry(flag_carry), .flag_ovf(flag_ovf),
    .flag_low(flag_low), .flag_eq(flag_eq), .flag_high(flag_high), .done(done));

  // {type, opcode, a, b, expected A, expected B, {carry, ovf, low, eq, high}}
  localparam int NV = 18;
  localparam logic [270:0] VEC [NV] = '{
    {2'd3, 8'hA4, 64'd5, 64'd7, 64'd12, 64'd7, 5'b00001},                 // R3
    {2'd0, 8'hA4, 64'hFF, 64'h01, 64'h00, 64'h01, 5'b10010},              // R3 R9
    {2'd0, 8'hA4, 64'h7F, 64'h01, 64'h80, 64'h01, 5'b01100},              // R3
    {2'd1, 8'hA5, 64'h3, 64'h5, 64'hFFFE, 64'h5, 5'b10100},               // R3
    {2'd2, 8'hA5, 64'h8000_0000, 64'h1, 64'h7FFF_FFFF, 64'h1, 5'b01001},  // R3
    {2'd3, 8'hAB, 64'hF0F0, 64'hFF00, 64'h0FF0, 64'hFF00, 5'b00001},      // R4
    {2'd0, 8'hAC, 64'hFFFF_FFFF_FFFF_FF3C, 64'h0F, 64'h0C, 64'h0F, 5'b00001}, // R4 R12
    {2'd3, 8'hAD, 64'h8000_0000_0000_0000, 64'h1, 64'h8000_0000_0000_0001, 64'h1, 5'b00100}, // R4
    {2'd3, 8'hA0, 64'h1111, 64'h8000_0000_0000_0002, 64'h8000_0000_0000_0002, 64'h1111, 5'b00100}, // R5
    {2'd0, 8'hA6, 64'h10, 64'h11, 64'h10, 64'h11, 5'b00001},              // R6
    {2'd0, 8'hAE, 64'hFF, 64'hFF, 64'hFE, 64'h01, 5'b00100},              // R6
    {2'd3, 8'hAE, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 64'h1, 64'hFFFF_FFFF_FFFF_FFFE, 5'b00001}, // R6
    {2'd1, 8'hA7, 64'd1000, 64'd7, 64'd142, 64'd7, 5'b00001},             // R7
    {2'd2, 8'hAF, 64'd100, 64'd7, 64'd2, 64'd14, 5'b00001},               // R7
    {2'd0, 8'hAF, 64'd5, 64'd9, 64'd5, 64'd0, 5'b00001},                  // R7
    {2'd3, 8'hA7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'b00100}, // R7
    {2'd2, 8'hA7, 64'h1234, 64'h1_0000_0000, 64'h1234, 64'h1_0000_0000, 5'b01001}, // R8 R12
    {2'd3, 8'hA5, 64'd5, 64'd5, 64'd0, 64'd5, 5'b00010}                   // R9
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Issue one opcode; returns cycles from the start edge to the done sample.
  task automatic run_op(input logic [7:0] op, input logic [63:0] a, input logic [63:0] b,
                        output int cycles);
    @(negedge clk);
    start = 1'b1; opcode = op; a_in = a; b_in = b;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    while (!done && cycles < 300) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic set_type(input int t);
    int c;
    run_op(8'hE8 | 8'(t), '0, '0, c);
    cur_type = t;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] pa, pb;
    logic [4:0]  pf;
    repeat (3) @(negedge clk);
    // R1 reset state, during reset and just after release
    check("R1", "A in reset", a_out, 64'h0);
    check("R1", "done in reset", {63'h0, done}, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "B after reset", b_out, 64'h0);
    check("R1", "flags after reset",
          {59'h0, flag_carry, flag_ovf, flag_low, flag_eq, flag_high}, 64'h0);
    // R1: the reset type is 64-bit, so this add carries past bit 8 without a carry flag
    run_op(8'hA4, 64'hFF, 64'h01, lat);
    check("R1", "64-bit default width", a_out, 64'h100);

    // vector walk: R3 R4 R5 R6 R7 R8 R9 R12
    for (int i = 0; i < NV; i++) begin
      logic [270:0] v;
      v = VEC[i];
      if (int'(v[270:269]) != cur_type) set_type(int'(v[270:269]));
      run_op(v[268:261], v[260:197], v[196:133], lat);
      check($sformatf("R3-R9 vec%0d", i), "A", a_out, v[132:69]);
      check($sformatf("R3-R9 vec%0d", i), "B", b_out, v[68:5]);
      check($sformatf("R9 vec%0d", i), "flags",
            {59'h0, flag_carry, flag_ovf, flag_low, flag_eq, flag_high}, {59'h0, v[4:0]});
    end

    // R11 single-cycle latency
    set_type(3);
    run_op(8'hAB, 64'h5, 64'h3, lat);
    check("R11", "single-cycle latency", 64'(lat), 64'd1);

    // R2 invalid type code keeps the 8-bit width; outputs held over the type opcodes
    set_type(0);
    pa = a_out; pb = b_out;
    pf = {flag_carry, flag_ovf, flag_low, flag_eq, flag_high};
    run_op(8'hED, 64'h1234, 64'h5678, lat);
    check("R2", "A held over type op", a_out, pa);
    check("R2", "B held over type op", b_out, pb);
    check("R2", "flags held over type op", {59'h0, flag_carry, flag_ovf, flag_low, flag_eq, flag_high},
          {59'h0, pf});
    run_op(8'hA4, 64'hFF, 64'h01, lat);
    check("R2", "width still 8 after code 5", {63'h0, flag_carry}, 64'h1);
    check("R2", "8-bit wrap", a_out, 64'h0);

    // R10 unused operate opcode and a non-operate opcode only pulse done
    pa = a_out; pb = b_out;
    pf = {flag_carry, flag_ovf, flag_low, flag_eq, flag_high};
    run_op(8'hA1, 64'h77, 64'h22, lat);
    check("R10", "done latency unused op", 64'(lat), 64'd1);
    check("R10", "A held unused op", a_out, pa);
    check("R10", "B held unused op", b_out, pb);
    check("R10", "flags held unused op",
          {59'h0, flag_carry, flag_ovf, flag_low, flag_eq, flag_high}, {59'h0, pf});
    run_op(8'h40, 64'h99, 64'h98, lat);
    check("R10", "A held outside op", a_out, pa);

    // R11 a start during a running multiply is ignored; latency bound w+3
    set_type(3);
    @(negedge clk);
    start = 1'b1; opcode = 8'hA6; a_in = 64'd3; b_in = 64'd5;
    @(negedge clk);
    opcode = 8'hA4; a_in = 64'd100; b_in = 64'd1;
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    check("R11", "mul latency within bound", 64'(lat <= 67), 64'd1);
    check("R11", "ignored start, A", a_out, 64'd15);
    check("R11", "ignored start, B", b_out, 64'd5);
    @(negedge clk);
    check("R11", "done is a pulse", {63'h0, done}, 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule